// File: doc/BRIEF.md
# Floppy Controller Command Dispatcher

This block is the front end that takes a command byte written by the host into the controller's command register and decides what happens next. It sorts the byte into one of four families: head positioning (Type I), sector transfer (Type II), whole-track or address transfer (Type III) and forced interrupt (Type IV). It sets or clears busy, clears the status flags that the new command makes stale, turns the spindle motor on, and counts out an optional spin-up wait and a head-settle wait on a millisecond tick. After that it sends a single start strobe to the execution engine that handles that family.

The stepping and data engines sit outside this block. They see the latched command byte and a write/read hint. They report error flags and a data-request event while they run, and they end the command with a done pulse. A forced interrupt is accepted at any time. It aborts whatever is pending and can raise the interrupt at once, raise it on the next index pulse, or raise nothing.

Top module: `fdc_cmd_dispatch`

## Requirements
- R1: Bit 7 clear gives Type I (start_step). Bits 7:6 = 10 give Type II (start_sector). Bits 7:6 = 11 with bits 5:4 other than 01 give Type III (start_track). Each accepted command produces exactly one start strobe, one cycle wide, and cmd_latched holds the accepted byte.
- R2: A byte with upper nibble 0xD is accepted even while busy. It cancels any pending wait so that no start strobe follows. It clears busy, drq and status bits 6 (write-protect), 3 (CRC) and 1 (index/DRQ).
- R3: In a forced interrupt, bit 3 set raises intrq on the next cycle. If bit 3 is clear and bit 2 is set, intrq rises after the next index pulse. If both are clear, intrq stays low.
- R4: After a forced interrupt, status bit 2 equals the track0 input level.
- R5: Any other command written while busy is ignored: cmd_latched is unchanged and no extra start strobe is produced.
- R6: Accepting a Type I command clears status bits 4 (record-not-found), 3 and 1, and clears drq. Bits 6, 5 and 2 keep their values.
- R7: Accepting a Type II command clears status bits 6, 5 (spin-up), 4, 2 (lost data) and 1, and keeps bit 3. op_write equals command bit 5.
- R8: Accepting a Type III command clears status bits 5, 4, 2 and 1, and keeps bits 6 and 3. op_write is 1 only for bits 5:4 = 11 (write track). Bits 5:4 = 10 (read track) and 00 (read address) give 0.
- R9: Accepting a command while the motor is off turns motor_on on. If command bit 3 is clear, the start waits SPINUP_MS extra ticks (default 1200). With the motor already on, or with bit 3 set, there is no spin-up wait.
- R10: A Type II or Type III command with bit 2 set waits a further SETTLE_MS ticks (default 30). For a Type I command, bit 2 adds no wait. The start strobe follows the edge on which the last required tick is seen.
- R11: Every command-register write clears intrq. An eng_done pulse while running ends the command: busy clears and intrq rises.
- R12: A Type II or Type III command written while drive_ready is low produces no start strobe. It leaves busy clear and raises intrq.
- R13: The status byte carries busy in bit 0 and motor-on in bit 7. The engine flags sit in bits 6..1. Everything reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_byte | input | 8 | Command byte |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| index_pulse | input | 1 | Disk index pulse |
| track0 | input | 1 | Head-at-track-zero level |
| drive_ready | input | 1 | Drive ready level |
| eng_done | input | 1 | Engine finished the running command |
| eng_drq | input | 1 | Engine requests a data transfer |
| eng_flags | input | 6 | Engine flag set pulses for status bits 6..1 (eng_flags[0] maps to bit 1) |
| status | output | 8 | Status byte |
| intrq | output | 1 | Interrupt request |
| drq | output | 1 | Data request |
| motor_on | output | 1 | Spindle motor enable |
| cmd_latched | output | 8 | Last accepted command byte |
| op_write | output | 1 | Accepted command writes to disk |
| start_step | output | 1 | Start strobe for the Type I engine |
| start_sector | output | 1 | Start strobe for the Type II engine |
| start_track | output | 1 | Start strobe for the Type III engine |

## Verification
The embedded properties assume that the engines pulse eng_done, eng_flags and eng_drq only while a command is running. They also assume the host never writes a command in the same cycle as eng_done. Stimulus follows both rules: every engine pulse is issued after the start strobe and before the done pulse, and every write is separated from other events by at least one idle cycle. Random command bytes are drawn with the forced-interrupt nibble remapped, so that the random phase covers the three execution families. Directed steps cover forced interrupts, the ready gate and the spin-up boundary.

// File: rtl/fdc_cmd_pkg.sv
package fdc_cmd_pkg;

  typedef enum logic [1:0] {
    CLS_T1 = 2'd0,
    CLS_T2 = 2'd1,
    CLS_T3 = 2'd2,
    CLS_FI = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } disp_state_e;

  // status bit positions (engines and host decode these)
  localparam int SB_BUSY  = 0;
  localparam int SB_IDX   = 1;
  localparam int SB_LOST  = 2;
  localparam int SB_CRC   = 3;
  localparam int SB_RNF   = 4;
  localparam int SB_SPIN  = 5;
  localparam int SB_WPROT = 6;
  localparam int SB_MOTOR = 7;

  localparam int FLAG_LO = 1;
  localparam int NFLAG   = 6;

  // flag clear mask, index i stands for status bit i+FLAG_LO
  function automatic logic [NFLAG-1:0] flag_clear(cmd_class_e c);
    logic [NFLAG-1:0] m;
    m = '0;
    unique case (c)
      CLS_T1: begin
        m[SB_IDX-FLAG_LO] = 1'b1;
        m[SB_CRC-FLAG_LO] = 1'b1;
        m[SB_RNF-FLAG_LO] = 1'b1;
      end
      CLS_T2: begin
        m[SB_IDX-FLAG_LO]   = 1'b1;
        m[SB_LOST-FLAG_LO]  = 1'b1;
        m[SB_RNF-FLAG_LO]   = 1'b1;
        m[SB_SPIN-FLAG_LO]  = 1'b1;
        m[SB_WPROT-FLAG_LO] = 1'b1;
      end
      CLS_T3: begin
        m[SB_IDX-FLAG_LO]  = 1'b1;
        m[SB_LOST-FLAG_LO] = 1'b1;
        m[SB_RNF-FLAG_LO]  = 1'b1;
        m[SB_SPIN-FLAG_LO] = 1'b1;
      end
      default: begin
        m[SB_IDX-FLAG_LO]   = 1'b1;
        m[SB_CRC-FLAG_LO]   = 1'b1;
        m[SB_WPROT-FLAG_LO] = 1'b1;
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_cmd_pkg::*;
(
  input  logic [7:2]  cmd,
  output cmd_class_e  cls,
  output logic        fi_now,
  output logic        fi_on_index,
  output logic        skip_spin,
  output logic        want_settle,
  output logic        is_write
);

  always_comb begin
    if (cmd[7:4] == 4'hD) begin
      cls = CLS_FI;
    end else if (!cmd[7]) begin
      cls = CLS_T1;
    end else if (!cmd[6]) begin
      cls = CLS_T2;
    end else begin
      cls = CLS_T3;
    end
  end

  always_comb begin
    fi_now      = cmd[3];
    fi_on_index = !cmd[3] && cmd[2];
    skip_spin   = cmd[3];
    want_settle = cmd[2] && ((cls == CLS_T2) || (cls == CLS_T3));
    unique case (cls)
      CLS_T2:  is_write = cmd[5];
      CLS_T3:  is_write = cmd[5] && cmd[4];
      default: is_write = 1'b0;
    endcase
  end

endmodule

// File: rtl/fdc_delay_timer.sv
module fdc_delay_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R10: without a tick the remaining wait never moves
  p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/fdc_status_bits.sv
module fdc_status_bits
  import fdc_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             set_en,
  input  logic [NFLAG-1:0] set_bits,
  input  logic             tr0_load,
  input  logic             tr0_lvl,
  output logic [NFLAG-1:0] flags
);

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    logic kept;
    assign kept = (flag_q[gi] | (set_en & set_bits[gi])) & ~(clr_en & clr_mask[gi]);
    if (gi + FLAG_LO == SB_LOST) begin : g_lost
      assign flag_d[gi] = tr0_load ? tr0_lvl : kept;
    end else begin : g_plain
      assign flag_d[gi] = kept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

  // R4: after a forced interrupt the lost/track-zero bit mirrors the input
  p_tr0_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tr0_load |=> (flags[SB_LOST-FLAG_LO] == $past(tr0_lvl)));

endmodule

// File: rtl/fdc_cmd_dispatch.sv
module fdc_cmd_dispatch
  import fdc_cmd_pkg::*;
#(
  parameter int SPINUP_MS = 1200,
  parameter int SETTLE_MS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       ms_tick,
  input  logic       index_pulse,
  input  logic       track0,
  input  logic       drive_ready,
  input  logic       eng_done,
  input  logic       eng_drq,
  input  logic [5:0] eng_flags,
  output logic [7:0] status,
  output logic       intrq,
  output logic       drq,
  output logic       motor_on,
  output logic [7:0] cmd_latched,
  output logic       op_write,
  output logic       start_step,
  output logic       start_sector,
  output logic       start_track
);

  localparam int TOTAL_MS = SPINUP_MS + SETTLE_MS;
  localparam int CNT_W    = $clog2(TOTAL_MS + 1);
  localparam int N_ENG    = 3;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // command decode
  cmd_class_e cls;
  logic       fi_now;
  logic       fi_on_index;
  logic       skip_spin;
  logic       want_settle;
  logic       is_write;

  fdc_cmd_decode u_decode (
    .cmd         (cmd_byte[7:2]),
    .cls         (cls),
    .fi_now      (fi_now),
    .fi_on_index (fi_on_index),
    .skip_spin   (skip_spin),
    .want_settle (want_settle),
    .is_write    (is_write)
  );

  // state
  disp_state_e      state_q, state_d;
  cmd_class_e       cls_q;
  logic [7:0]       cmd_q;
  logic             opw_q;
  logic             motor_q, motor_d;
  logic             intrq_q, intrq_d;
  logic             arm_q, arm_d;
  logic             drq_q, drq_d;
  logic [N_ENG-1:0] start_q, start_d;

  logic busy;
  logic fi_hit;
  logic accept;
  logic reject;
  logic launch;
  logic done_hit;
  logic index_hit;
  logic expired;
  logic go;

  assign busy      = (state_q != ST_IDLE);
  assign fi_hit    = cmd_wr && (cls == CLS_FI);
  assign accept    = cmd_wr && (cls != CLS_FI) && !busy;
  assign reject    = accept && ((cls == CLS_T2) || (cls == CLS_T3)) && !drive_ready;
  assign launch    = accept && !reject;
  assign done_hit  = eng_done && (state_q == ST_RUN);
  assign index_hit = arm_q && index_pulse && !cmd_wr;
  assign go        = (state_q == ST_WAIT) && expired && !fi_hit;

  // wait length
  logic [CNT_W-1:0] spin_part;
  logic [CNT_W-1:0] settle_part;
  logic [CNT_W-1:0] wait_val;

  always_comb begin
    spin_part   = (!motor_q && !skip_spin) ? CNT_W'(SPINUP_MS) : '0;
    settle_part = want_settle ? CNT_W'(SETTLE_MS) : '0;
    wait_val    = spin_part + settle_part;
  end

  fdc_delay_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (launch),
    .load_val (wait_val),
    .tick     (ms_tick),
    .expired  (expired)
  );

  // status flags 6..1
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] clr_mask;

  assign clr_mask = flag_clear(fi_hit ? CLS_FI : cls);

  fdc_status_bits u_flags (
    .clk      (clk),
    .rst_n    (rst_ni),
    .clr_en   (fi_hit || launch),
    .clr_mask (clr_mask),
    .set_en   (state_q == ST_RUN),
    .set_bits (eng_flags),
    .tr0_load (fi_hit),
    .tr0_lvl  (track0),
    .flags    (flags)
  );

  // next state
  always_comb begin
    state_d = state_q;
    if (fi_hit) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch)   state_d = ST_WAIT;
        ST_WAIT: if (expired)  state_d = ST_RUN;
        ST_RUN:  if (eng_done) state_d = ST_IDLE;
        default:               state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    motor_d = motor_q | launch;

    if (fi_hit && fi_now)                 intrq_d = 1'b1;
    else if (done_hit || reject)          intrq_d = 1'b1;
    else if (index_hit)                   intrq_d = 1'b1;
    else if (cmd_wr)                      intrq_d = 1'b0;
    else                                  intrq_d = intrq_q;

    if (fi_hit && fi_on_index)            arm_d = 1'b1;
    else if (cmd_wr || index_pulse)       arm_d = 1'b0;
    else                                  arm_d = arm_q;

    if (fi_hit || (launch && (cls == CLS_T1))) drq_d = 1'b0;
    else if (eng_drq && (state_q == ST_RUN))   drq_d = 1'b1;
    else                                       drq_d = drq_q;
  end

  for (genvar gi = 0; gi < N_ENG; gi++) begin : g_start
    assign start_d[gi] = go && (2'(cls_q) == 2'(gi));
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      motor_q <= 1'b0;
      intrq_q <= 1'b0;
      arm_q   <= 1'b0;
      drq_q   <= 1'b0;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      motor_q <= motor_d;
      intrq_q <= intrq_d;
      arm_q   <= arm_d;
      drq_q   <= drq_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      cls_q <= CLS_T1;
      opw_q <= 1'b0;
    end else if (accept) begin
      cmd_q <= cmd_byte;
      cls_q <= cls;
      opw_q <= is_write;
    end
  end

  // outputs
  assign status       = {motor_q, flags, busy};
  assign intrq        = intrq_q;
  assign drq          = drq_q;
  assign motor_on     = motor_q;
  assign cmd_latched  = cmd_q;
  assign op_write     = opw_q;
  assign start_step   = start_q[0];
  assign start_sector = start_q[1];
  assign start_track  = start_q[2];

  // R1: at most one engine started, and only inside a command
  p_one_start_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({start_step, start_sector, start_track}));
  p_start_inside_busy_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_step || start_sector || start_track) |-> status[SB_BUSY]);
  // R2: forced interrupt always drops busy and blocks the start
  p_fi_idles_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    fi_hit |=> (!status[SB_BUSY] && !drq && !(start_step || start_sector || start_track)));
  // R5: writes during busy leave the latched command alone
  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && busy && !fi_hit) |=> $stable(cmd_latched));
  // R9: any launch leaves the motor running
  p_motor_on_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    launch |=> motor_on);
  // R11: a plain command write drops the interrupt
  p_intrq_clear_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && !fi_hit && !reject && !eng_done) |=> !intrq);
  // R12: not-ready rejection ends at once with an interrupt
  p_reject_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    reject |=> (intrq && !status[SB_BUSY]));

endmodule

// File: tb/tb_fdc_cmd_dispatch.sv
module tb_fdc_cmd_dispatch;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       ms_tick = 1'b0;
  logic       index_pulse = 1'b0;
  logic       track0 = 1'b0;
  logic       drive_ready = 1'b1;
  logic       eng_done = 1'b0;
  logic       eng_drq = 1'b0;
  logic [5:0] eng_flags = '0;
  logic [7:0] status;
  logic       intrq, drq, motor_on, op_write;
  logic [7:0] cmd_latched;
  logic       start_step, start_sector, start_track;

  int n_chk = 0;
  int n_err = 0;
  int s1 = 0, s2 = 0, s3 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_cmd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .ms_tick(ms_tick), .index_pulse(index_pulse), .track0(track0),
    .drive_ready(drive_ready), .eng_done(eng_done), .eng_drq(eng_drq),
    .eng_flags(eng_flags), .status(status), .intrq(intrq), .drq(drq),
    .motor_on(motor_on), .cmd_latched(cmd_latched), .op_write(op_write),
    .start_step(start_step), .start_sector(start_sector), .start_track(start_track)
  );

  always @(negedge clk) begin
    if (start_step)   s1++;
    if (start_sector) s2++;
    if (start_track)  s3++;
  end

  function automatic int exp_class(input logic [7:0] c);
    if (c[7:4] == 4'hD) return 3;
    if (!c[7]) return 0;
    if (!c[6]) return 1;
    return 2;
  endfunction

  function automatic logic [7:0] exp_mask(input int cl);
    case (cl)
      0:       return 8'h1A;
      1:       return 8'h76;
      2:       return 8'h36;
      default: return 8'h4A;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
  endtask

  task automatic done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic flags(input logic [5:0] f);
    @(negedge clk); eng_flags = f;
    @(negedge clk); eng_flags = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int b1, b2, b3;
    void'($urandom(32'h5EED1234));
    do_reset();

    // R13 reset state
    chk("R13 reset status", status, 8'h00);
    chk("R13 reset intrq", intrq, 0);
    chk("R13 reset drq", drq, 0);
    chk("R13 reset motor", motor_on, 0);

    // R9 spin-up with motor off, bit 3 clear
    wr(8'h00);
    chk("R13 busy+motor after accept", status, 8'h81);
    b1 = s1;
    tick(1199); idle(3);
    chk("R9 no start before spin-up ends", s1 - b1, 0);
    tick(1); idle(2);
    chk("R1 R9 start after spin-up", s1 - b1, 1);
    done();
    chk("R11 done raises intrq", intrq, 1);
    chk("R11 done clears busy", status[0], 0);

    // R11 write clears intrq; motor already on, no spin-up (R9)
    b1 = s1;
    wr(8'h08);
    chk("R11 write clears intrq", intrq, 0);
    idle(2);
    chk("R9 no spin-up with motor on", s1 - b1, 1);
    done();

    // R10 settle on Type II, R5 ignored write
    b2 = s2;
    wr(8'h8C);
    tick(29); idle(3);
    chk("R10 no start before settle", s2 - b2, 0);
    tick(1); idle(2);
    chk("R10 start after settle", s2 - b2, 1);
    chk("R7 read sector op_write", op_write, 0);
    wr(8'hA8);
    chk("R5 latched unchanged", cmd_latched, 8'h8C);
    idle(5);
    chk("R5 no extra start", s2 - b2, 1);
    flags(6'h3F);
    chk("R13 all flags set", status, 8'hFF);
    done();
    chk("R13 busy clear after done", status, 8'hFE);

    // R8 write track clears selected flags
    b3 = s3;
    wr(8'hF8);
    chk("R8 Type III status clear", status, 8'hC9);
    chk("R8 write track op_write", op_write, 1);
    idle(3);
    chk("R1 track engine started", s3 - b3, 1);
    done();

    // R10 Type I with bit 2: no settle
    b1 = s1;
    wr(8'h0C);
    idle(2);
    chk("R10 Type I ignores settle bit", s1 - b1, 1);
    flags(6'h3F);
    @(negedge clk); eng_drq = 1'b1; @(negedge clk); eng_drq = 1'b0;
    chk("R6 drq set by engine", drq, 1);

    // R2 R4 forced interrupt while running
    track0 = 1'b1;
    wr(8'hD0);
    chk("R2 R4 FI status", status, 8'hB4);
    chk("R2 FI clears drq", drq, 0);
    chk("R3 FI no flags no intrq", intrq, 0);

    // R2 R3 R4 FI during settle wait
    track0 = 1'b0;
    b2 = s2;
    wr(8'h84);
    tick(10);
    wr(8'hD8);
    chk("R3 immediate intrq", intrq, 1);
    chk("R2 R4 FI mid-wait status", status, 8'h80);
    tick(40); idle(3);
    chk("R2 wait cancelled", s2 - b2, 0);

    // R3 index-armed interrupt
    wr(8'hD4);
    chk("R11 FI write clears intrq", intrq, 0);
    idle(4);
    chk("R3 armed waits for index", intrq, 0);
    @(negedge clk); index_pulse = 1'b1; @(negedge clk); index_pulse = 1'b0;
    chk("R3 index raises intrq", intrq, 1);
    wr(8'hD0);
    @(negedge clk); index_pulse = 1'b1; @(negedge clk); index_pulse = 1'b0;
    chk("R3 plain FI ignores index", intrq, 0);

    // R12 not ready
    drive_ready = 1'b0;
    b2 = s2;
    wr(8'h88);
    chk("R12 busy clear", status[0], 0);
    chk("R12 intrq raised", intrq, 1);
    idle(5);
    chk("R12 no start", s2 - b2, 0);
    drive_ready = 1'b1;

    // random commands, R1 R6 R7 R8 R9 R10
    for (int it = 0; it < 60; it++) begin
      logic [7:0] c;
      logic [7:0] pre;
      int cl, d, a1, a2, a3;
      c = 8'($urandom);
      if (c[7:4] == 4'hD) c[4] = 1'b0;
      cl = exp_class(c);
      pre = status;
      a1 = s1; a2 = s2; a3 = s3;
      wr(c);
      chk(cl == 0 ? "R6 status clear" : (cl == 1 ? "R7 status clear" : "R8 status clear"),
          status, (pre & ~exp_mask(cl)) | 8'h01);
      d = (c[2] && cl != 0) ? 30 : 0;
      if (d != 0) tick(d);
      idle(3);
      chk("R1 R9 R10 one start to matching engine",
          {8'(s3 - a3), 8'(s2 - a2), 8'(s1 - a1)},
          cl == 0 ? 32'h1 : (cl == 1 ? 32'h100 : 32'h10000));
      chk("R1 latched byte", cmd_latched, c);
      if (cl == 1) chk("R7 op_write", op_write, c[5]);
      if (cl == 2) chk("R8 op_write", op_write, c[5] & c[4]);
      flags(6'($urandom));
      done();
      chk("R11 done intrq", intrq, 1);
    end

    // R9 motor off, bit 3 set: immediate start
    do_reset();
    b1 = s1;
    wr(8'h18);
    chk("R9 motor turned on", motor_on, 1);
    idle(2);
    chk("R9 bit3 skips spin-up", s1 - b1, 1);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule